// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

A synchronous two-port word memory whose storage is split into many small, independent banks. Each port registers its bank number, in-bank word address, chip enables, byte-lane enables, write strobe and write data on the rising edge of a clock shared by both ports. Either port may reach any bank. When both ports hold an access to the same bank in the same cycle, the block flags a collision on both ports, drops both writes and reports no valid read data on either side.

Each word is four 9-bit lanes, and a write changes only the lanes whose enable is active. Each port has its own static mode pin that chooses the read latency. In flow-through mode read data appears in the cycle after the address is captured. In pipelined mode it appears one cycle later, from an extra output register. An output-enable pin per port gates that port's read data and read-valid strobe without waiting for a clock edge.

The default build has 64 banks of 16 words so that it elaborates quickly. Setting `ADDR_BITS` to 11 gives 64 banks of 2K words of 36 bits, which is 128K words in total.

Top module: `dpb_bank_ram`

## Requirements
- R1: A write to bank `bank`, word `addr` is returned by any later read of the same bank and word from either port. Words in other banks, and other words in the same bank, are not changed.
- R2: Inputs are sampled on the rising edge. In flow-through mode (`pipe_i`=0), a read captured at edge k drives `rdata_o` and `rvalid_o`=1 from just after edge k until edge k+1. The data includes every write captured at edge k-1 or earlier.
- R3: `be_ni[i]`=0 enables lane i, which is bits `[9i+8:9i]`. Only the enabled lanes of the word are written, and the other lanes keep their old contents.
- R4: When both ports hold active accesses to the same bank, both `coll_o` are 1 during the cycle after capture. Neither write changes the memory, and neither port gets `rvalid_o`=1 for those reads.
- R5: Accesses by the two ports to different banks in the same cycle both take effect, with `coll_o`=0.
- R6: An access is active only when `ce0_ni`=0 and `ce1_i`=1. An inactive port writes nothing, gets no `rvalid_o` and takes no part in collisions.
- R7: A write access (`we_i`=1) never produces `rvalid_o`=1.
- R8: In pipelined mode (`pipe_i`=1), the read data for an access captured at edge k is presented from edge k+1 until edge k+2.
- R9: While `oe_ni`=1, that port's `rvalid_o` is 0 without waiting for a clock edge. `rdata_o` is all zeros whenever `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ce0_ni | input | 1 | Port A chip enable, active low |
| a_ce1_i | input | 1 | Port A chip enable, active high |
| a_we_i | input | 1 | Port A: 1 = write, 0 = read |
| a_bank_i | input | BANK_BITS | Port A bank number |
| a_addr_i | input | ADDR_BITS | Port A word address inside the bank |
| a_be_ni | input | NUM_LANES | Port A lane enables, active low |
| a_wdata_i | input | NUM_LANES*LANE_W | Port A write data |
| a_pipe_i | input | 1 | Port A mode: 1 = pipelined, 0 = flow-through (static) |
| a_oe_ni | input | 1 | Port A output enable, active low, acts without a clock |
| a_rdata_o | output | NUM_LANES*LANE_W | Port A read data |
| a_rvalid_o | output | 1 | Port A read data valid |
| a_coll_o | output | 1 | Port A bank collision flag |
| b_ce0_ni | input | 1 | Port B chip enable, active low |
| b_ce1_i | input | 1 | Port B chip enable, active high |
| b_we_i | input | 1 | Port B: 1 = write, 0 = read |
| b_bank_i | input | BANK_BITS | Port B bank number |
| b_addr_i | input | ADDR_BITS | Port B word address inside the bank |
| b_be_ni | input | NUM_LANES | Port B lane enables, active low |
| b_wdata_i | input | NUM_LANES*LANE_W | Port B write data |
| b_pipe_i | input | 1 | Port B mode: 1 = pipelined, 0 = flow-through (static) |
| b_oe_ni | input | 1 | Port B output enable, active low, acts without a clock |
| b_rdata_o | output | NUM_LANES*LANE_W | Port B read data |
| b_rvalid_o | output | 1 | Port B read data valid |
| b_coll_o | output | 1 | Port B bank collision flag |

## Verification
The bench drives same-bank collisions of every kind: write against write, write against read and read against read. A design that resolved conflicts per address, or let one port win, would change a word or raise `rvalid_o` where the model does not. Partial-lane writes would expose a design that writes the whole word. Each of the two ports is run in each mode, including mixed modes. A latency off by one in either mode shows up as read data in the wrong cycle. The bench also flips output enable half a cycle away from the clock edge, so a design that registers it would still report valid data at the instant of the check.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int unsigned DEF_BANK_BITS = 6;
  localparam int unsigned DEF_ADDR_BITS = 4;
  localparam int unsigned DEF_NUM_LANES = 4;
  localparam int unsigned DEF_LANE_W    = 9;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dpb_port_in.sv
module dpb_port_in #(
  parameter int unsigned BANK_BITS = 6,
  parameter int unsigned ADDR_BITS = 4,
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 9,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce0_ni,
  input  logic                 ce1_i,
  input  logic                 we_i,
  input  logic [BANK_BITS-1:0] bank_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [NUM_LANES-1:0] be_ni,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 acc_o,
  output logic                 wr_o,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [ADDR_BITS-1:0] addr_o,
  output logic [NUM_LANES-1:0] be_o,
  output logic [DATA_W-1:0]    wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= 1'b0;
      wr_o    <= 1'b0;
      bank_o  <= '0;
      addr_o  <= '0;
      be_o    <= '0;
      wdata_o <= '0;
    end else begin
      acc_o   <= ~ce0_ni & ce1_i;
      wr_o    <= we_i;
      bank_o  <= bank_i;
      addr_o  <= addr_i;
      be_o    <= ~be_ni;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/dpb_bank.sv
module dpb_bank #(
  parameter int unsigned ADDR_BITS = 4,
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 9,
  localparam int unsigned DATA_W   = NUM_LANES * LANE_W,
  localparam int unsigned DEPTH    = 1 << ADDR_BITS
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [1:0]                        we_i,
  input  logic [1:0][ADDR_BITS-1:0]         addr_i,
  input  logic [1:0][NUM_LANES-1:0]         be_i,
  input  logic [1:0][DATA_W-1:0]            wdata_i,
  output logic [1:0][DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (we_i[p] && be_i[p][l])
          mem_q[addr_i[p]][l*LANE_W +: LANE_W] <= wdata_i[p][l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o[0] = mem_q[addr_i[0]];
  assign rdata_o[1] = mem_q[addr_i[1]];

  // a bank never sees two writers in one cycle
  p_one_writer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i[0] && we_i[1]));
endmodule

// File: rtl/dpb_rd_out.sv
module dpb_rd_out
  import dpb_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              oe_ni,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  rd_mode_e          mode;
  logic              pv_q;
  logic [DATA_W-1:0] pd_q;
  logic              v;
  logic [DATA_W-1:0] d;

  assign mode = rd_mode_e'(pipe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= rd_en_i;
      pd_q <= rdata_i;
    end
  end

  always_comb begin
    v = (mode == MODE_PIPE) ? pv_q : rd_en_i;
    d = (mode == MODE_PIPE) ? pd_q : rdata_i;
    rvalid_o = v & ~oe_ni;
    rdata_o  = rvalid_o ? d : '0;
  end

  p_oe_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!rvalid_o && rdata_o == '0));

  p_pipe_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && rvalid_o) |-> $past(rd_en_i));
endmodule

// File: rtl/dpb_bank_ram.sv
module dpb_bank_ram
  import dpb_pkg::*;
#(
  parameter int unsigned BANK_BITS = DEF_BANK_BITS,
  parameter int unsigned ADDR_BITS = DEF_ADDR_BITS,
  parameter int unsigned NUM_LANES = DEF_NUM_LANES,
  parameter int unsigned LANE_W    = DEF_LANE_W,
  localparam int unsigned DATA_W    = NUM_LANES * LANE_W,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 a_ce0_ni,
  input  logic                 a_ce1_i,
  input  logic                 a_we_i,
  input  logic [BANK_BITS-1:0] a_bank_i,
  input  logic [ADDR_BITS-1:0] a_addr_i,
  input  logic [NUM_LANES-1:0] a_be_ni,
  input  logic [DATA_W-1:0]    a_wdata_i,
  input  logic                 a_pipe_i,
  input  logic                 a_oe_ni,
  output logic [DATA_W-1:0]    a_rdata_o,
  output logic                 a_rvalid_o,
  output logic                 a_coll_o,
  input  logic                 b_ce0_ni,
  input  logic                 b_ce1_i,
  input  logic                 b_we_i,
  input  logic [BANK_BITS-1:0] b_bank_i,
  input  logic [ADDR_BITS-1:0] b_addr_i,
  input  logic [NUM_LANES-1:0] b_be_ni,
  input  logic [DATA_W-1:0]    b_wdata_i,
  input  logic                 b_pipe_i,
  input  logic                 b_oe_ni,
  output logic [DATA_W-1:0]    b_rdata_o,
  output logic                 b_rvalid_o,
  output logic                 b_coll_o
);
  logic [1:0]                ce0_n, ce1, we, pipe, oe_n;
  logic [1:0][BANK_BITS-1:0] bank_in;
  logic [1:0][ADDR_BITS-1:0] addr_in;
  logic [1:0][NUM_LANES-1:0] be_n_in;
  logic [1:0][DATA_W-1:0]    wd_in;

  logic [1:0]                acc_q, wr_q;
  logic [1:0][BANK_BITS-1:0] bank_q;
  logic [1:0][ADDR_BITS-1:0] addr_q;
  logic [1:0][NUM_LANES-1:0] be_q;
  logic [1:0][DATA_W-1:0]    wd_q;

  logic                      coll;
  logic [1:0]                wr_ok, rd_en, rvalid;
  logic [1:0][DATA_W-1:0]    port_rd, rdata;
  logic [1:0][DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign ce0_n   = {b_ce0_ni, a_ce0_ni};
  assign ce1     = {b_ce1_i, a_ce1_i};
  assign we      = {b_we_i, a_we_i};
  assign pipe    = {b_pipe_i, a_pipe_i};
  assign oe_n    = {b_oe_ni, a_oe_ni};
  assign bank_in = {b_bank_i, a_bank_i};
  assign addr_in = {b_addr_i, a_addr_i};
  assign be_n_in = {b_be_ni, a_be_ni};
  assign wd_in   = {b_wdata_i, a_wdata_i};

  // conflicts resolved per bank, not per word
  assign coll = acc_q[0] & acc_q[1] & (bank_q[0] == bank_q[1]);

  for (genvar p = 0; p < 2; p++) begin : g_port
    dpb_port_in #(
      .BANK_BITS(BANK_BITS), .ADDR_BITS(ADDR_BITS),
      .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
    ) u_in (
      .clk_i, .rst_ni,
      .ce0_ni(ce0_n[p]), .ce1_i(ce1[p]), .we_i(we[p]),
      .bank_i(bank_in[p]), .addr_i(addr_in[p]), .be_ni(be_n_in[p]),
      .wdata_i(wd_in[p]),
      .acc_o(acc_q[p]), .wr_o(wr_q[p]), .bank_o(bank_q[p]),
      .addr_o(addr_q[p]), .be_o(be_q[p]), .wdata_o(wd_q[p])
    );

    assign wr_ok[p]   = acc_q[p] & wr_q[p] & ~coll;
    assign rd_en[p]   = acc_q[p] & ~wr_q[p] & ~coll;
    assign port_rd[p] = bank_rd[bank_q[p]][p];

    dpb_rd_out #(.DATA_W(DATA_W)) u_out (
      .clk_i, .rst_ni,
      .pipe_i(pipe[p]), .oe_ni(oe_n[p]), .rd_en_i(rd_en[p]),
      .rdata_i(port_rd[p]), .rdata_o(rdata[p]), .rvalid_o(rvalid[p])
    );

    p_coll_flow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pipe[p] && coll) |-> !rvalid[p]);
    p_coll_pipe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pipe[p] && $past(coll)) |-> !rvalid[p]);
    p_inactive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_q[p] |-> !coll);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [1:0] bwe;
    assign bwe[0] = wr_ok[0] & (bank_q[0] == BANK_BITS'(b));
    assign bwe[1] = wr_ok[1] & (bank_q[1] == BANK_BITS'(b));

    dpb_bank #(
      .ADDR_BITS(ADDR_BITS), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
    ) u_bank (
      .clk_i, .rst_ni,
      .we_i(bwe), .addr_i(addr_q), .be_i(be_q), .wdata_i(wd_q),
      .rdata_o(bank_rd[b])
    );
  end

  assign a_rdata_o  = rdata[0];
  assign b_rdata_o  = rdata[1];
  assign a_rvalid_o = rvalid[0];
  assign b_rvalid_o = rvalid[1];
  assign a_coll_o   = coll;
  assign b_coll_o   = coll;
endmodule

// File: tb/tb_dpb_bank_ram.sv
module tb_dpb_bank_ram;
  localparam int BB = 6;
  localparam int AB = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int WORDS = 1 << (BB + AB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]          ce0_n, ce1, we, pipe, oe_n;
  logic [1:0][BB-1:0]  bank;
  logic [1:0][AB-1:0]  addr;
  logic [1:0][NL-1:0]  be_n;
  logic [1:0][DW-1:0]  wd;
  logic [DW-1:0]       a_rd, b_rd;
  logic                a_rv, b_rv, a_co, b_co;

  dpb_bank_ram dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_ce0_ni(ce0_n[0]), .a_ce1_i(ce1[0]), .a_we_i(we[0]), .a_bank_i(bank[0]),
    .a_addr_i(addr[0]), .a_be_ni(be_n[0]), .a_wdata_i(wd[0]), .a_pipe_i(pipe[0]),
    .a_oe_ni(oe_n[0]), .a_rdata_o(a_rd), .a_rvalid_o(a_rv), .a_coll_o(a_co),
    .b_ce0_ni(ce0_n[1]), .b_ce1_i(ce1[1]), .b_we_i(we[1]), .b_bank_i(bank[1]),
    .b_addr_i(addr[1]), .b_be_ni(be_n[1]), .b_wdata_i(wd[1]), .b_pipe_i(pipe[1]),
    .b_oe_ni(oe_n[1]), .b_rdata_o(b_rd), .b_rvalid_o(b_rv), .b_coll_o(b_co)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [DW-1:0] mm [int];
  bit            c_acc [2];
  bit            c_wr [2];
  int            c_key [2];
  int            c_bank [2];
  logic [NL-1:0] c_be [2];
  logic [DW-1:0] c_wd [2];
  bit            p_v [2];
  logic [DW-1:0] p_d [2];

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_coll();
    return c_acc[0] && c_acc[1] && (c_bank[0] == c_bank[1]);
  endfunction

  task automatic model_clear();
    for (int p = 0; p < 2; p++) begin
      c_acc[p] = 0; c_wr[p] = 0; c_key[p] = 0; c_bank[p] = 0;
      c_be[p] = '0; c_wd[p] = '0; p_v[p] = 0; p_d[p] = '0;
    end
  endtask

  task automatic model_edge();
    bit co;
    co = m_coll();
    for (int p = 0; p < 2; p++) begin
      bit ren;
      ren = c_acc[p] && !c_wr[p] && !co;
      p_v[p] = ren;
      p_d[p] = ren ? mm[c_key[p]] : '0;
    end
    for (int p = 0; p < 2; p++) begin
      if (c_acc[p] && c_wr[p] && !co) begin
        logic [DW-1:0] w;
        w = mm.exists(c_key[p]) ? mm[c_key[p]] : '0;
        for (int l = 0; l < NL; l++)
          if (c_be[p][l]) w[l*LW +: LW] = c_wd[p][l*LW +: LW];
        mm[c_key[p]] = w;
      end
    end
    for (int p = 0; p < 2; p++) begin
      c_acc[p]  = !ce0_n[p] && ce1[p];
      c_wr[p]   = we[p];
      c_bank[p] = int'(bank[p]);
      c_key[p]  = int'({bank[p], addr[p]});
      c_be[p]   = ~be_n[p];
      c_wd[p]   = wd[p];
    end
  endtask

  task automatic compare();
    bit co;
    co = m_coll();
    for (int p = 0; p < 2; p++) begin
      bit ren, ev;
      logic [DW-1:0] ed, ad;
      logic av, ac;
      string req;
      ren = c_acc[p] && !c_wr[p] && !co;
      ev  = (pipe[p] ? p_v[p] : ren) && !oe_n[p];
      ed  = ev ? (pipe[p] ? p_d[p] : mm[c_key[p]]) : '0;
      ad  = p ? b_rd : a_rd;
      av  = p ? b_rv : a_rv;
      ac  = p ? b_co : a_co;
      if (co) req = "R4";
      else if (oe_n[p]) req = "R9";
      else if (pipe[p]) req = "R8";
      else if (!c_acc[p]) req = "R6";
      else if (c_wr[p]) req = "R7";
      else req = "R2";
      chk(co ? "R4" : (c_acc[0] && c_acc[1] ? "R5" : "R6"),
          p ? "b_coll" : "a_coll", DW'(ac), DW'(co));
      chk(req, p ? "b_rvalid" : "a_rvalid", DW'(av), DW'(ev));
      chk(ev ? cur_req : "R9", p ? "b_rdata" : "a_rdata", ad, ed);
    end
  endtask

  // caller drives at negedge; check after oe change, then after the edge
  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_edge();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic idle(int p);
    ce0_n[p] = 1'b1; ce1[p] = 1'b0; we[p] = 1'b0; bank[p] = '0;
    addr[p] = '0; be_n[p] = '1; wd[p] = '0; oe_n[p] = 1'b0;
  endtask

  task automatic drive(int p, bit w, int bk, int ad, logic [NL-1:0] ben, logic [DW-1:0] d);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; we[p] = w; bank[p] = BB'(bk);
    addr[p] = AB'(ad); be_n[p] = ben; wd[p] = d;
  endtask

  task automatic do_reset(bit pa, bit pb);
    @(negedge clk);
    rst_n = 1'b0;
    idle(0); idle(1);
    pipe = {pb, pa};
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset a_rvalid", DW'(a_rv), '0);
    chk("R2", "reset b_rvalid", DW'(b_rv), '0);
    chk("R4", "reset coll", DW'({a_co, b_co}), '0);
    chk("R9", "reset a_rdata", a_rd, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rand_port(int p);
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    ce0_n[p] = ($urandom() % 10) == 0;
    ce1[p]   = ($urandom() % 10) != 0;
    we[p]    = ($urandom() % 3) == 0;
    bank[p]  = (($urandom() % 2) == 0) ? BB'($urandom() % 3) : BB'($urandom());
    addr[p]  = AB'($urandom());
    be_n[p]  = NL'($urandom());
    wd[p]    = t[DW-1:0];
    oe_n[p]  = ($urandom() % 7) == 0;
  endtask

  task automatic random_run(int n);
    cur_req = "R1";
    for (int i = 0; i < n; i++) begin
      rand_port(0);
      rand_port(1);
      cycle();
    end
    idle(0); idle(1);
    repeat (3) cycle();
  endtask

  task automatic directed();
    // R3: lanes 1 and 3 disabled
    cur_req = "R3";
    drive(0, 1, 5, 3, 4'b0000, 36'h1_2345_6789); idle(1); cycle();
    drive(0, 1, 5, 3, 4'b1010, 36'hA_BCDE_F012); cycle();
    drive(0, 0, 5, 3, 4'b1111, '0); cycle();
    idle(0); repeat (2) cycle();
    // R5: concurrent accesses to different banks
    cur_req = "R5";
    drive(0, 1, 7, 2, 4'b0000, 36'h5_5555_5555);
    drive(1, 0, 9, 4, 4'b1111, '0); cycle();
    drive(0, 0, 9, 4, 4'b1111, '0);
    drive(1, 0, 7, 2, 4'b1111, '0); cycle();
    idle(0); idle(1); repeat (2) cycle();
    // R4: same bank writes and reads, different words
    cur_req = "R4";
    drive(0, 1, 11, 1, 4'b0000, 36'hF_0F0F_0F0F);
    drive(1, 1, 11, 6, 4'b0000, 36'h0_F0F0_F0F0); cycle();
    drive(0, 0, 11, 6, 4'b1111, '0);
    drive(1, 0, 11, 1, 4'b1111, '0); cycle();
    drive(0, 0, 11, 1, 4'b1111, '0); idle(1); cycle();
    // R9: output enable dropped while a read is held
    cur_req = "R9";
    drive(0, 0, 11, 1, 4'b1111, '0); cycle();
    oe_n[0] = 1'b1; cycle();
    oe_n[0] = 1'b0; cycle();
    idle(0); idle(1); repeat (3) cycle();
  endtask

  initial begin
    idle(0); idle(1);
    pipe = 2'b00;
    model_clear();
    do_reset(1'b0, 1'b0);
    // preload every word (R1)
    cur_req = "R1";
    for (int w = 0; w < WORDS; w++) begin
      drive(0, 1, w >> AB, w % (1 << AB), 4'b0000, DW'(w * 36'h0_0101_0103));
      idle(1);
      cycle();
    end
    idle(0);
    repeat (2) cycle();
    directed();
    random_run(2500);
    do_reset(1'b1, 1'b1);
    directed();
    random_run(2500);
    do_reset(1'b1, 1'b0);
    random_run(2000);
    do_reset(1'b0, 1'b1);
    random_run(2000);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule